// File: doc/BRIEF.md
# Single-Precision Sign, Compare and Min/Max Unit

This unit carries out the non-arithmetic binary32 operations of a 64-bit integer core that has a single-precision floating-point extension. Each issued operation reads two 32-bit floating-point operands, and in one case a 64-bit integer operand. It returns exactly one of two kinds of result. The first kind is a 32-bit floating-point value, produced by a sign injection, a minimum, a maximum or a move from the integer side. The second kind is a 64-bit integer value, produced by an equality or ordering flag or by a move of the raw float bit pattern. Every operation also returns an invalid-operation flag.

The operation logic is purely combinational. One register stage sits behind it, loaded when `op_valid` is high, so the result appears one clock after issue. NaN handling for the compares and for min/max follows the usual quiet/signaling rules. The min/max ordering places negative zero below positive zero.

Top module: `fpmisc_unit`

## Requirements
- R1: A result is registered one clock after issue. `res_valid` equals the `op_valid` of the previous cycle. When `op_valid` is low, `res_fp`, `res_int` and `res_invalid` keep their values.
- R2: While `rst_n` is low, `res_valid`, `res_fp`, `res_int` and `res_invalid` are all zero.
- R3: Op code 0 (plain injection) returns `src_a` with bit 31 replaced by bit 31 of `src_b`.
- R4: Op code 1 (negated injection) returns `src_a` with bit 31 replaced by the inverse of bit 31 of `src_b`.
- R5: Op code 2 (xor injection) returns `src_a` with bit 31 replaced by the XOR of the two sign bits.
- R6: Op codes 3 (equal), 4 (less) and 5 (less-or-equal) write exactly 1 or 0 into `res_int`, with bits 63:1 zero. For these compares +0.0 and -0.0 are equal.
- R7: Every compare with a NaN operand returns 0. A NaN has all exponent bits set and a non-zero mantissa; it is signaling when mantissa bit 22 is 0. Less and less-or-equal raise invalid for any NaN. Equal raises invalid only for a signaling NaN.
- R8: Op code 6 (min) returns the smaller operand and op code 7 (max) returns the larger one. -0.0 counts as smaller than +0.0.
- R9: For min and max, when exactly one operand is NaN the other operand is returned. When both are NaN the result is 0x7FC00000. Any signaling NaN input raises invalid.
- R10: Op code 8 (float to integer move) puts `src_a` in bits 31:0 of `res_int` and copies bit 31 into bits 63:32.
- R11: Op code 9 (integer to float move) returns bits 31:0 of `src_int` unchanged. The injections and both moves never raise invalid and never change NaN payloads.
- R12: `res_fp` is zero for integer-side ops (codes 3, 4, 5, 8). `res_int` is zero for float-side ops (codes 0, 1, 2, 6, 7, 9). Codes 10 to 15 give all-zero results and no invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Issue strobe; loads the result register |
| op_sel | input | 4 | Operation code |
| src_a | input | 32 | First binary32 operand |
| src_b | input | 32 | Second binary32 operand |
| src_int | input | 64 | Integer operand for the integer-to-float move |
| res_valid | output | 1 | Result register holds a fresh result |
| res_fp | output | 32 | Floating-point result |
| res_int | output | 64 | Integer-side result |
| res_invalid | output | 1 | Invalid-operation flag |

## Verification
A min/max or a compare can produce its data result and raise the invalid flag in the same cycle. A min with one signaling NaN, for example, returns the other operand and also sets invalid. The bench drives such mixed cases: signaling and quiet NaNs in either operand, NaN pairs, and signed-zero pairs. It judges the returned value and the flag together against values computed from the requirements. Back-to-back issues followed by an idle cycle with changed inputs show that the register updates and holds as required.

// File: rtl/fpmisc_pkg.sv
package fpmisc_pkg;
  localparam int EXP_W = 8;
  localparam int MAN_W = 23;
  localparam int FLEN  = 1 + EXP_W + MAN_W;
  localparam int XLEN  = 64;
  localparam int OP_W  = 4;

  typedef enum logic [OP_W-1:0] {
    OP_SGNJ  = 4'd0,
    OP_SGNJN = 4'd1,
    OP_SGNJX = 4'd2,
    OP_EQ    = 4'd3,
    OP_LT    = 4'd4,
    OP_LE    = 4'd5,
    OP_MIN   = 4'd6,
    OP_MAX   = 4'd7,
    OP_MV_X  = 4'd8,
    OP_MV_F  = 4'd9
  } fop_e;

  typedef struct packed {
    logic sign;
    logic is_zero;
    logic is_nan;
    logic is_snan;
  } fcls_t;
endpackage

// File: rtl/fpmisc_classify.sv
module fpmisc_classify
  import fpmisc_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int MW = MAN_W
) (
  input  logic [EW+MW:0] val,
  output fcls_t          cls
);
  localparam int W = EW + MW + 1;

  logic exp_ones;
  logic man_nz;

  always_comb begin
    exp_ones    = &val[W-2 -: EW];
    man_nz      = |val[MW-1:0];
    cls.sign    = val[W-1];
    cls.is_zero = ~|val[W-2:0];
    cls.is_nan  = exp_ones & man_nz;
    cls.is_snan = exp_ones & man_nz & ~val[MW-1];
  end
endmodule

// File: rtl/fpmisc_signinj.sv
module fpmisc_signinj
  import fpmisc_pkg::*;
#(
  parameter int W = FLEN
) (
  input  fop_e         op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  logic new_sign;

  always_comb begin
    unique case (op)
      OP_SGNJN: new_sign = ~b[W-1];
      OP_SGNJX: new_sign = a[W-1] ^ b[W-1];
      default:  new_sign = b[W-1];
    endcase
    res = {new_sign, a[W-2:0]};
  end
endmodule

// File: rtl/fpmisc_order.sv
module fpmisc_order
  import fpmisc_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int MW = MAN_W
) (
  input  logic [EW+MW:0] a,
  input  logic [EW+MW:0] b,
  input  fcls_t          ca,
  input  fcls_t          cb,
  output logic           eq_f,
  output logic           lt_f,
  output logic           le_f,
  output logic [EW+MW:0] min_v,
  output logic [EW+MW:0] max_v
);
  localparam int W = EW + MW + 1;
  localparam logic [W-1:0] QNAN = {1'b0, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};

  logic any_nan, both_nan, both_zero, mag_lt, mag_gt, tot_lt;

  always_comb begin
    any_nan   = ca.is_nan | cb.is_nan;
    both_nan  = ca.is_nan & cb.is_nan;
    both_zero = ca.is_zero & cb.is_zero;
    mag_lt    = a[W-2:0] < b[W-2:0];
    mag_gt    = a[W-2:0] > b[W-2:0];
    // total order on non-NaN values, -0 below +0
    if (ca.sign != cb.sign) tot_lt = ca.sign;
    else                    tot_lt = ca.sign ? mag_gt : mag_lt;

    eq_f = ~any_nan & ((a == b) | both_zero);
    lt_f = ~any_nan & ~both_zero & tot_lt;
    le_f = lt_f | eq_f;

    if (both_nan)       begin min_v = QNAN; max_v = QNAN; end
    else if (ca.is_nan) begin min_v = b;    max_v = b;    end
    else if (cb.is_nan) begin min_v = a;    max_v = a;    end
    else begin
      min_v = tot_lt ? a : b;
      max_v = tot_lt ? b : a;
    end
  end
endmodule

// File: rtl/fpmisc_unit.sv
module fpmisc_unit
  import fpmisc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [OP_W-1:0]  op_sel,
  input  logic [FLEN-1:0]  src_a,
  input  logic [FLEN-1:0]  src_b,
  input  logic [XLEN-1:0]  src_int,
  output logic             res_valid,
  output logic [FLEN-1:0]  res_fp,
  output logic [XLEN-1:0]  res_int,
  output logic             res_invalid
);
  localparam int NSRC = 2;

  fop_e             op;
  logic [FLEN-1:0]  opnd [NSRC];
  fcls_t            cls  [NSRC];
  logic [FLEN-1:0]  inj_v, min_v, max_v;
  logic             eq_f, lt_f, le_f;
  logic [FLEN-1:0]  fp_d;
  logic [XLEN-1:0]  int_d;
  logic             inv_d;

  assign op      = fop_e'(op_sel);
  assign opnd[0] = src_a;
  assign opnd[1] = src_b;

  for (genvar g = 0; g < NSRC; g++) begin : g_cls
    fpmisc_classify #(.EW(EXP_W), .MW(MAN_W)) u_cls (
      .val (opnd[g]),
      .cls (cls[g])
    );
  end

  fpmisc_signinj #(.W(FLEN)) u_inj (
    .op  (op),
    .a   (src_a),
    .b   (src_b),
    .res (inj_v)
  );

  fpmisc_order #(.EW(EXP_W), .MW(MAN_W)) u_ord (
    .a     (src_a),
    .b     (src_b),
    .ca    (cls[0]),
    .cb    (cls[1]),
    .eq_f  (eq_f),
    .lt_f  (lt_f),
    .le_f  (le_f),
    .min_v (min_v),
    .max_v (max_v)
  );

  // next-state selection
  always_comb begin
    fp_d  = '0;
    int_d = '0;
    inv_d = 1'b0;
    case (op)
      OP_SGNJ, OP_SGNJN, OP_SGNJX: fp_d = inj_v;
      OP_EQ: begin
        int_d = {{(XLEN-1){1'b0}}, eq_f};
        inv_d = cls[0].is_snan | cls[1].is_snan;
      end
      OP_LT: begin
        int_d = {{(XLEN-1){1'b0}}, lt_f};
        inv_d = cls[0].is_nan | cls[1].is_nan;
      end
      OP_LE: begin
        int_d = {{(XLEN-1){1'b0}}, le_f};
        inv_d = cls[0].is_nan | cls[1].is_nan;
      end
      OP_MIN: begin
        fp_d  = min_v;
        inv_d = cls[0].is_snan | cls[1].is_snan;
      end
      OP_MAX: begin
        fp_d  = max_v;
        inv_d = cls[0].is_snan | cls[1].is_snan;
      end
      OP_MV_X: int_d = {{(XLEN-FLEN){src_a[FLEN-1]}}, src_a};
      OP_MV_F: fp_d  = src_int[FLEN-1:0];
      default: ;
    endcase
  end

  // result register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_fp      <= '0;
      res_int     <= '0;
      res_invalid <= 1'b0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        res_fp      <= fp_d;
        res_int     <= int_d;
        res_invalid <= inv_d;
      end
    end
  end
endmodule

// File: rtl/fpmisc_unit_chk.sv
module fpmisc_unit_chk
  import fpmisc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic [OP_W-1:0]  op_sel,
  input logic [FLEN-1:0]  src_a,
  input logic [FLEN-1:0]  src_b,
  input logic [XLEN-1:0]  src_int,
  input logic             res_valid,
  input logic [FLEN-1:0]  res_fp,
  input logic [XLEN-1:0]  res_int,
  input logic             res_invalid
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);
  a_r1_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !res_valid);
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(res_fp) && $stable(res_int) && $stable(res_invalid)));
  a_r3_sgnj: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == OP_SGNJ) |=>
      (res_fp == {$past(src_b[FLEN-1]), $past(src_a[FLEN-2:0])}));
  a_r4_sgnjn: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == OP_SGNJN) |=>
      (res_fp == {~$past(src_b[FLEN-1]), $past(src_a[FLEN-2:0])}));
  a_r6_flag_width: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_sel == OP_EQ || op_sel == OP_LT || op_sel == OP_LE)) |=>
      (res_int[XLEN-1:1] == '0 && res_fp == '0));
  a_r7_nan_cmp_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_sel == OP_LT || op_sel == OP_LE) &&
     ((&src_a[30:23] && |src_a[22:0]) || (&src_b[30:23] && |src_b[22:0]))) |=>
      (res_int == '0 && res_invalid));
  a_r9_both_nan: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_sel == OP_MIN || op_sel == OP_MAX) &&
     (&src_a[30:23] && |src_a[22:0]) && (&src_b[30:23] && |src_b[22:0])) |=>
      (res_fp == 32'h7FC0_0000));
  a_r10_sext: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == OP_MV_X) |=>
      (res_int[XLEN-1:FLEN] == {(XLEN-FLEN){res_int[FLEN-1]}}));
  a_r11_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_sel <= OP_SGNJX || op_sel == OP_MV_X || op_sel == OP_MV_F)) |=>
      !res_invalid);
  a_r11_mvf_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == OP_MV_F) |=> (res_fp == $past(src_int[FLEN-1:0])));
endmodule

bind fpmisc_unit fpmisc_unit_chk u_chk (.*);

// File: tb/fpmisc_unit_tb_top.sv
module fpmisc_unit_tb_top;
  import fpmisc_pkg::*;

  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [3:0]  op_sel;
  logic [31:0] src_a, src_b;
  logic [63:0] src_int;
  logic        res_valid;
  logic [31:0] res_fp;
  logic [63:0] res_int;
  logic        res_invalid;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  localparam logic [31:0] P1 = 32'h3F80_0000, M1 = 32'hBF80_0000;
  localparam logic [31:0] P2 = 32'h4000_0000, M2 = 32'hC000_0000;
  localparam logic [31:0] PZ = 32'h0000_0000, MZ = 32'h8000_0000;
  localparam logic [31:0] QN = 32'h7FC0_0001, SN = 32'h7F80_0001;
  localparam logic [31:0] CN = 32'h7FC0_0000;

  fpmisc_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .src_a(src_a), .src_b(src_b), .src_int(src_int),
    .res_valid(res_valid), .res_fp(res_fp), .res_int(res_int),
    .res_invalid(res_invalid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, register at posedge, sample at next negedge
  task automatic issue(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [63:0] si);
    op_valid = 1'b1; op_sel = op; src_a = a; src_b = b; src_int = si;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R2 res_valid", {63'b0, res_valid}, 64'd0);
    chk("R2 res_fp", {32'b0, res_fp}, 64'd0);
    chk("R2 res_int", res_int, 64'd0);
    chk("R2 res_invalid", {63'b0, res_invalid}, 64'd0);
  endtask

  task automatic t_sign_inject;
    issue(OP_SGNJ, P1, M2, '0);
    chk("R3 sgnj", {32'b0, res_fp}, {32'b0, M1});
    chk("R1 res_valid", {63'b0, res_valid}, 64'd1);
    chk("R12 res_int zero", res_int, 64'd0);
    issue(OP_SGNJN, P1, M2, '0);
    chk("R4 sgnjn", {32'b0, res_fp}, {32'b0, P1});
    issue(OP_SGNJX, M1, M2, '0);
    chk("R5 sgnjx", {32'b0, res_fp}, {32'b0, P1});
    issue(OP_SGNJ, SN, MZ, '0);
    chk("R11 sgnj payload", {32'b0, res_fp}, 64'h0000_0000_FF80_0001);
    chk("R11 sgnj no invalid", {63'b0, res_invalid}, 64'd0);
  endtask

  task automatic t_compare;
    issue(OP_EQ, P1, P1, '0);
    chk("R6 eq 1==1", res_int, 64'd1);
    chk("R12 res_fp zero", {32'b0, res_fp}, 64'd0);
    issue(OP_EQ, PZ, MZ, '0);
    chk("R6 eq +0==-0", res_int, 64'd1);
    issue(OP_LT, M2, M1, '0);
    chk("R6 lt -2<-1", res_int, 64'd1);
    issue(OP_LT, M1, M2, '0);
    chk("R6 lt -1<-2", res_int, 64'd0);
    issue(OP_LE, P2, P2, '0);
    chk("R6 le 2<=2", res_int, 64'd1);
    issue(OP_LT, MZ, PZ, '0);
    chk("R6 lt -0<+0", res_int, 64'd0);
    chk("R6 no invalid", {63'b0, res_invalid}, 64'd0);
  endtask

  task automatic t_compare_nan;
    issue(OP_EQ, QN, P1, '0);
    chk("R7 eq qnan", res_int, 64'd0);
    chk("R7 eq qnan flag", {63'b0, res_invalid}, 64'd0);
    issue(OP_EQ, SN, P1, '0);
    chk("R7 eq snan", res_int, 64'd0);
    chk("R7 eq snan flag", {63'b0, res_invalid}, 64'd1);
    issue(OP_LT, QN, P1, '0);
    chk("R7 lt qnan", res_int, 64'd0);
    chk("R7 lt qnan flag", {63'b0, res_invalid}, 64'd1);
    issue(OP_LE, P1, SN, '0);
    chk("R7 le snan", res_int, 64'd0);
    chk("R7 le snan flag", {63'b0, res_invalid}, 64'd1);
  endtask

  task automatic t_minmax;
    issue(OP_MIN, P1, P2, '0);
    chk("R8 min", {32'b0, res_fp}, {32'b0, P1});
    issue(OP_MAX, M1, M2, '0);
    chk("R8 max", {32'b0, res_fp}, {32'b0, M1});
    issue(OP_MIN, PZ, MZ, '0);
    chk("R8 min zeros", {32'b0, res_fp}, {32'b0, MZ});
    issue(OP_MAX, MZ, PZ, '0);
    chk("R8 max zeros", {32'b0, res_fp}, {32'b0, PZ});
    chk("R8 no invalid", {63'b0, res_invalid}, 64'd0);
    issue(OP_MIN, QN, P2, '0);
    chk("R9 min qnan", {32'b0, res_fp}, {32'b0, P2});
    chk("R9 min qnan flag", {63'b0, res_invalid}, 64'd0);
    issue(OP_MAX, P2, SN, '0);
    chk("R9 max snan", {32'b0, res_fp}, {32'b0, P2});
    chk("R9 max snan flag", {63'b0, res_invalid}, 64'd1);
    issue(OP_MIN, QN, SN, '0);
    chk("R9 both nan", {32'b0, res_fp}, {32'b0, CN});
    chk("R9 both nan flag", {63'b0, res_invalid}, 64'd1);
  endtask

  task automatic t_moves;
    issue(OP_MV_X, M1, P1, '0);
    chk("R10 mvx neg", res_int, 64'hFFFF_FFFF_BF80_0000);
    issue(OP_MV_X, P1, M1, '0);
    chk("R10 mvx pos", res_int, 64'h0000_0000_3F80_0000);
    issue(OP_MV_F, P1, P1, 64'h1234_5678_7F80_0001);
    chk("R11 mvf", {32'b0, res_fp}, 64'h0000_0000_7F80_0001);
    chk("R11 mvf no invalid", {63'b0, res_invalid}, 64'd0);
    chk("R12 mvf res_int", res_int, 64'd0);
  endtask

  task automatic t_unused_code;
    issue(4'd12, SN, QN, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R12 code12 fp", {32'b0, res_fp}, 64'd0);
    chk("R12 code12 int", res_int, 64'd0);
    chk("R12 code12 flag", {63'b0, res_invalid}, 64'd0);
  endtask

  task automatic t_hold;
    issue(OP_LT, QN, P1, '0);
    op_valid = 1'b0; op_sel = OP_MV_X; src_a = M2; src_b = P2;
    @(negedge clk);
    chk("R1 idle valid", {63'b0, res_valid}, 64'd0);
    chk("R1 hold int", res_int, 64'd0);
    chk("R1 hold flag", {63'b0, res_invalid}, 64'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_sel = '0;
    src_a = '0; src_b = '0; src_int = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_sign_inject();
    t_compare();
    t_compare_nan();
    t_minmax();
    t_moves();
    t_unused_code();
    t_hold();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule